// File: doc/BRIEF.md
# Dual-Output Serial Flash Burst Reader

This block masters a serial flash bus to fetch a run of consecutive bytes with the two-pin fast-read command. A host sets the clock polarity and the SCK half period, places a start address and a byte count on its inputs, and pulses `start`. The block lowers chip select and clocks out the command and the address on data line 0, one bit per clock. It then runs the dummy clocks and releases line 0. After that it collects two bits per clock from both data lines and assembles them into bytes.

Each finished byte is presented on a valid/ready stream. If the consumer holds off, the serial clock pauses at a byte boundary, so no data is lost. After the last byte, chip select rises. It stays high for at least one full SCK period, and then a one-cycle `done` pulse marks the end of the request.

Top module: `dual_read_engine`

## Requirements
- R1: After reset: `cs_n`=1, `io0_oe`=0, `busy`=0, `done`=0, `m_valid`=0, and `sck` rests at `cfg_cpol`.
- R2: Once `cs_n` falls, the first 8 SCK rising edges carry the command byte 0x3B on `io0_o`, most significant bit first.
- R3: SCK rising edges 9 to 32 carry the 24-bit start address on `io0_o`, most significant bit first. Address bits at position ADDR_BITS (default 22) and above are sent as 0.
- R4: Eight dummy clocks follow the address. `io0_oe` is 1 from the fall of `cs_n` through the last address bit, and it goes to 0 at the rising edge of the final dummy clock. It remains 0 on every falling edge on which the device drives data.
- R5: Each data clock carries two bits, sampled on the SCK rising edge. `io1_i` carries byte bits 7, 5, 3, 1 and `io0_i` carries bits 6, 4, 2, 0, in that order. Four clocks make one byte.
- R6: While `cs_n` is high, `sck` rests at `cfg_cpol`: 0 selects mode 0 and 1 selects mode 3. Output bits change on SCK falling edges.
- R7: Each SCK half period lasts `cfg_half` clock cycles. A value of 0 acts as 1.
- R8: Exactly `start_len` bytes are delivered, in ascending address order, within a single `cs_n`-low window. `cs_n` then returns high.
- R9: After a transfer, `cs_n` stays high for at least 2×`cfg_half` cycles before `done` is raised.
- R10: While `m_valid`=1 and `m_ready`=0, `m_data` is held and `m_valid` stays 1. SCK waits at a byte boundary, so no byte is overwritten.
- R11: A `start` pulse while `busy`=1 is ignored. The running transfer keeps its address and count.
- R12: `start` with `start_len`=0 gives a `done` pulse on the next cycle and leaves `cs_n` high.
- R13: `done` is a one-cycle pulse, raised only when `busy`=0, `m_valid`=0 and `cs_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | SCK idle level (0 = mode 0, 1 = mode 3) |
| cfg_half | input | HALF_W | SCK half period in clock cycles |
| start | input | 1 | Request strobe |
| start_addr | input | 24 | First byte address |
| start_len | input | LEN_W | Number of bytes to read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock |
| io0_o | output | 1 | Data line 0 output value |
| io0_oe | output | 1 | Data line 0 output enable |
| io0_i | input | 1 | Data line 0 input |
| io1_i | input | 1 | Data line 1 input |
| m_data | output | 8 | Assembled byte |
| m_valid | output | 1 | Byte available |
| m_ready | input | 1 | Consumer accepts byte |

## Verification
The hardest case to reach is a stalled serial clock exactly where the command phase hands over to the data phase, or between two bytes. A stall there must not shift a pair twice and must not drop a pair. To reach it, a slow consumer raises `m_ready` for only two cycles in every nine, across half periods of 1 to 3 cycles. With a one-cycle half period a byte completes faster than it is drained, so the stall path is taken on most byte boundaries. A flash model with its own edge counter drives the interleaved bit pairs and checks line 0 turnaround. The sweep covers both clock polarities and burst lengths of 1, 2 and 5.

// File: rtl/dre_pkg.sv
package dre_pkg;
  localparam int OPC_BITS = 8;
  localparam int ADDR_W   = 24;
  localparam int BYTE_W   = 8;
  localparam int LANES    = 2;
  localparam logic [OPC_BITS-1:0] RD_OPCODE = 8'h3B;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
  } rd_state_t;
endpackage

// File: rtl/dre_half_timer.sv
module dre_half_timer #(
  parameter int HALF_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic [HALF_W-1:0] half_eff;

  assign half_eff = (half == '0) ? HALF_W'(1) : half;
  assign tick     = run && (cnt == half_eff - HALF_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HALF_W'(1);
  end
endmodule

// File: rtl/dre_lane_collect.sv
module dre_lane_collect #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [LANES-1:0]  lanes_in,
  output logic [BYTE_W-1:0] next_o
);
  logic [BYTE_W-1:0] col;

  // Upper lane index carries the more significant bit of each group.
  assign next_o = {col[BYTE_W-LANES-1:0], lanes_in};

  always_ff @(posedge clk) begin
    if (rst)           col <= '0;
    else if (shift_en) col <= next_o;
  end
endmodule

// File: rtl/dre_out_stage.sv
module dre_out_stage #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         m_ready,
  output logic [W-1:0] m_data,
  output logic         m_valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // The engine must never deliver a byte into a stalled slot (R10).
  assert_no_overwrite_R10: assert property (@(posedge clk) disable iff (rst)
    load |-> !(m_valid && !m_ready));
endmodule

// File: rtl/dual_read_engine.sv
module dual_read_engine
  import dre_pkg::*;
#(
  parameter int HALF_W       = 8,
  parameter int LEN_W        = 12,
  parameter int ADDR_BITS    = 22,
  parameter int DUMMY_CLOCKS = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_cpol,
  input  logic [HALF_W-1:0] cfg_half,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              busy,
  output logic              done,
  output logic              cs_n,
  output logic              sck,
  output logic              io0_o,
  output logic              io0_oe,
  input  logic              io0_i,
  input  logic              io1_i,
  output logic [BYTE_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready
);
  localparam int CMD_CLOCKS = OPC_BITS + ADDR_W + DUMMY_CLOCKS;
  localparam int CNT_W      = $clog2(CMD_CLOCKS);
  localparam int SH_W       = OPC_BITS + ADDR_W;
  localparam int PAIRS      = BYTE_W / LANES;
  localparam int PC_W       = (PAIRS > 1) ? $clog2(PAIRS) : 1;
  localparam logic [CNT_W-1:0]  LAST_CMD  = CNT_W'(CMD_CLOCKS - 1);
  localparam logic [PC_W-1:0]   LAST_PAIR = PC_W'(PAIRS - 1);
  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'((64'd1 << ADDR_BITS) - 64'd1);

  rd_state_t        state;
  logic             tick;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cmd_cnt;
  logic             in_data;
  logic [PC_W-1:0]  pair_cnt;
  logic [LEN_W-1:0] bytes_left;
  logic             gap2;
  logic [BYTE_W-1:0] byte_next;
  logic             sample_en, byte_load, out_full, at_byte_start, finished;

  dre_half_timer #(.HALF_W(HALF_W)) u_timer (
    .clk(clk), .rst(rst), .run(state != ST_IDLE), .half(cfg_half), .tick(tick));

  assign sample_en = (state == ST_LOW) && tick && in_data;
  assign byte_load = sample_en && (pair_cnt == LAST_PAIR);

  dre_lane_collect #(.BYTE_W(BYTE_W), .LANES(LANES)) u_collect (
    .clk(clk), .rst(rst), .shift_en(sample_en),
    .lanes_in({io1_i, io0_i}), .next_o(byte_next));

  dre_out_stage #(.W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .load(byte_load), .din(byte_next),
    .m_ready(m_ready), .m_data(m_data), .m_valid(m_valid));

  assign out_full      = m_valid && !m_ready;
  assign at_byte_start = in_data ? (pair_cnt == '0) : (cmd_cnt == LAST_CMD);
  assign finished      = in_data && (pair_cnt == '0) && (bytes_left == '0);
  assign io0_o         = sh_q[SH_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  cs_n <= 1'b1;  sck <= 1'b0;  io0_oe <= 1'b0;
      sh_q <= '0;  cmd_cnt <= '0;  in_data <= 1'b0;  pair_cnt <= '0;
      bytes_left <= '0;  gap2 <= 1'b0;  busy <= 1'b0;  done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          sck <= cfg_cpol;
          if (start) begin
            if (start_len == '0) begin
              done <= 1'b1;
            end else begin
              state <= ST_SETUP;  cs_n <= 1'b0;  io0_oe <= 1'b1;  busy <= 1'b1;
              sh_q <= {RD_OPCODE, start_addr & ADDR_MASK};
              cmd_cnt <= '0;  in_data <= 1'b0;  pair_cnt <= '0;
              bytes_left <= start_len;
            end
          end
        end
        ST_SETUP: if (tick) begin
          sck <= 1'b0;  state <= ST_LOW;
        end
        ST_LOW: if (tick) begin
          sck <= 1'b1;  state <= ST_HIGH;
          if (in_data) begin
            pair_cnt <= (pair_cnt == LAST_PAIR) ? '0 : pair_cnt + PC_W'(1);
            if (pair_cnt == LAST_PAIR) bytes_left <= bytes_left - LEN_W'(1);
          end else if (cmd_cnt == LAST_CMD) begin
            io0_oe <= 1'b0;
          end
        end
        ST_HIGH: if (tick) begin
          if (finished) begin
            sck <= cfg_cpol;  state <= ST_TAIL;
          end else if (!(at_byte_start && out_full)) begin
            sck <= 1'b0;  state <= ST_LOW;
            if (!in_data) begin
              if (cmd_cnt == LAST_CMD) in_data <= 1'b1;
              else begin
                cmd_cnt <= cmd_cnt + CNT_W'(1);
                sh_q    <= {sh_q[SH_W-2:0], 1'b0};
              end
            end
          end
        end
        ST_TAIL: if (tick) begin
          cs_n <= 1'b1;  gap2 <= 1'b0;  state <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          if (!gap2) gap2 <= 1'b1;
          else if (!m_valid) begin
            done <= 1'b1;  busy <= 1'b0;  state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_drive_in_data_R4: assert property (@(posedge clk) disable iff (rst)
    in_data |-> !io0_oe);

  assert_oe_within_cs_R4: assert property (@(posedge clk) disable iff (rst)
    io0_oe |-> !cs_n);

  assert_idle_level_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_n) |-> (sck == cfg_cpol));

  assert_done_clean_R13: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !m_valid && cs_n));

  assert_done_single_R13: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/tb_dual_read_engine.sv
module tb_dual_read_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_cpol = 1'b0;
  logic [7:0] cfg_half = 8'd1;
  logic start = 1'b0;
  logic [23:0] start_addr = '0;
  logic [11:0] start_len = '0;
  logic busy, done, cs_n, sck, io0_o, io0_oe;
  logic io0_i = 1'b0, io1_i = 1'b0;
  logic [7:0] m_data;
  logic m_valid;
  logic m_ready = 1'b1;

  always #10 clk = ~clk;

  dual_read_engine dut (
    .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_half(cfg_half),
    .start(start), .start_addr(start_addr), .start_len(start_len),
    .busy(busy), .done(done), .cs_n(cs_n), .sck(sck), .io0_o(io0_o),
    .io0_oe(io0_oe), .io0_i(io0_i), .io1_i(io1_i), .m_data(m_data),
    .m_valid(m_valid), .m_ready(m_ready));

  int checks = 0;
  int errors = 0;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return 8'((a[7:0] * 8'd7) ^ a[15:8] ^ a[23:16] ^ 8'h3C);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Flash model: counts SCK rising edges while selected.
  int rcount = 0;
  logic [31:0] sh_in = '0;
  int oe_err = 0;
  logic cs_prev = 1'b1, sck_prev = 1'b0;
  always @(cs_n or sck) begin
    if (cs_prev && !cs_n) begin
      rcount = 0;
      sh_in = '0;
    end else if (!cs_n && !sck_prev && sck) begin
      if (rcount < 32) begin
        sh_in = {sh_in[30:0], io0_o};
        if (!io0_oe) oe_err++;
      end
      rcount++;
    end else if (!cs_n && sck_prev && !sck && rcount >= 40) begin
      int d;
      logic [7:0] b;
      d = rcount - 40;
      b = mem_byte(sh_in[23:0] + 24'(d / 4));
      io1_i = b[7 - 2*(d % 4)];
      io0_i = b[6 - 2*(d % 4)];
      if (io0_oe) oe_err++;
    end
    cs_prev = cs_n;
    sck_prev = sck;
  end

  // SCK high-time monitor over the command phase (R7).
  int hi_run = 0;
  int r7_err = 0;
  int half_exp = 1;
  always @(negedge clk) begin
    if (cs_n) hi_run = 0;
    else if (sck) hi_run++;
    else if (hi_run != 0) begin
      if (rcount <= 40 && hi_run != half_exp) r7_err++;
      hi_run = 0;
    end
  end

  // Chip-select high counter (R9).
  int cs_hi_cnt = 0;
  always @(negedge clk) begin
    if (cs_n) cs_hi_cnt++;
    else cs_hi_cnt = 0;
  end

  // Consumer with selectable ready pattern (R10).
  bit ready_mode = 0;
  int cyc = 0;
  int nrx = 0;
  logic [7:0] got [64];
  int r10_err = 0;
  logic stall_prev = 1'b0;
  logic [7:0] data_prev = '0;
  always @(negedge clk) begin
    cyc++;
    if (stall_prev && (!m_valid || m_data != data_prev)) r10_err++;
    m_ready = ready_mode ? ((cyc % 9) < 2) : 1'b1;
    if (m_valid && m_ready) begin
      got[nrx % 64] = m_data;
      nrx++;
    end
    stall_prev = m_valid && !m_ready;
    data_prev = m_data;
  end

  // Watchdog: an expired run is counted as one failed check.
  initial begin
    wait (cyc >= 150000);
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic run_txn(input logic cp, input int hv, input logic [23:0] addr,
                         input int ln, input bit rm, input bit inject);
    int heff, n0, oe0, r70, r100, w;
    bit seen;
    heff = (hv == 0) ? 1 : hv;
    cfg_cpol = cp;
    cfg_half = 8'(hv);
    half_exp = heff;
    ready_mode = rm;
    repeat (3) @(negedge clk);
    check(sck == cp, "R6 idle sck level", int'(sck), int'(cp));
    n0 = nrx; oe0 = oe_err; r70 = r7_err; r100 = r10_err;
    start_addr = addr; start_len = 12'(ln); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    if (inject) begin
      repeat (30) @(negedge clk);
      // R11: a second request while busy must have no effect
      start_addr = ~addr; start_len = 12'd3; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (w = 0; w < 20000 && !seen; w++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
    check(seen, "R8 done reached", int'(seen), 1);
    check(sh_in[31:24] == 8'h3B, "R2 opcode", int'(sh_in[31:24]), 'h3B);
    check(sh_in[23:0] == (addr & 24'h3FFFFF), inject ? "R3/R11 address" : "R3 address",
          int'(sh_in[23:0]), int'(addr & 24'h3FFFFF));
    check(nrx - n0 == ln, inject ? "R8/R11 byte count" : "R8 byte count", nrx - n0, ln);
    for (int i = 0; i < ln; i++) begin
      logic [7:0] e;
      e = mem_byte((addr & 24'h3FFFFF) + 24'(i));
      check(got[(n0 + i) % 64] == e, "R5 byte data", int'(got[(n0 + i) % 64]), int'(e));
    end
    check(oe_err == oe0, "R4 io0 turnaround", oe_err - oe0, 0);
    check(r7_err == r70, "R7 half period", r7_err - r70, 0);
    check(r10_err == r100, "R10 stall hold", r10_err - r100, 0);
    check(cs_n == 1'b1 && sck == cp, "R8 bus idle after done", int'({cs_n, sck}), int'({1'b1, cp}));
    check(!busy && !m_valid, "R13 done state", int'({busy, m_valid}), 0);
    check(cs_hi_cnt >= 2 * heff, "R9 cs high gap", cs_hi_cnt, 2 * heff);
    @(negedge clk);
    check(!done, "R13 single pulse", int'(done), 0);
  endtask

  initial begin
    int idx;
    int lens [3] = '{1, 2, 5};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1 && io0_oe == 1'b0, "R1 reset bus", int'({cs_n, io0_oe}), 2);
    check(!busy && !done && !m_valid, "R1 reset flags", int'({busy, done, m_valid}), 0);
    check(sck == 1'b0, "R1 reset sck", int'(sck), 0);

    // R12: zero-length request
    start_len = '0; start_addr = 24'h000123; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && cs_n == 1'b1 && !busy, "R12 zero length", int'({done, cs_n, busy}), 6);
    @(negedge clk);
    check(!done && cs_n, "R12 no transfer", int'({done, cs_n}), 1);

    idx = 0;
    for (int cp = 0; cp < 2; cp++)
      for (int hv = 1; hv <= 3; hv++)
        for (int li = 0; li < 3; li++)
          for (int rm = 0; rm < 2; rm++) begin
            logic [23:0] a;
            a = {2'(idx), 22'(22'h0ABCDE + idx * 22'h01357 + li * 22'h00F0FD)};
            run_txn(cp[0], hv, a, lens[li], rm[0], 1'b0);
            idx++;
          end

    run_txn(1'b0, 2, 24'h3FFFFE, 5, 1'b0, 1'b1);   // R11 with address wrap region
    run_txn(1'b1, 0, 24'hC00010, 2, 1'b1, 1'b0);   // R7 half value 0
    run_txn(1'b1, 3, 24'h412300, 5, 1'b1, 1'b1);   // R11 in mode 3 with stalls

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule